// File: doc/BRIEF.md
# Keyboard Wake-Up Interrupt Controller

This block watches a group of active-low key inputs and turns a key press into a pending flag and an interrupt request for a small processor. Each key has its own enable bit. A key only counts when its enable bit is 1. The keys pass through a two-stage synchronizer. The block then triggers on a falling edge, or, in the second sensitivity mode, on a falling edge or on a low level. The flag has its own mask, which holds back the request but still records the event. The request depends only on the block's own clock and registers and on nothing from the processor core, so it can bring the processor out of a low-power stop state.

Software reaches two byte-wide registers through a simple write port and a combinational read port. The control/status register holds the flag, an acknowledge bit that only acts when written, the mask and the mode. The second register holds the key enables. A debugger break-state input protects the flag: during a break, an acknowledge clears the flag only when the break-clear permission input is 1. A flag cleared that way stays cleared once the break ends.

Top module: `kbd_wake_ctrl`

## Requirements
- R1: After reset, both registers read 0x00 and `irq_o` is 0.
- R2: Reading the control register (address 0) returns 0 in bits 7..4 and in bit 2 (acknowledge) at all times. Bit 3 is the flag, bit 1 is the mask and bit 0 is the mode.
- R3: In mode 0, a 1-to-0 change on an enabled key sets the flag. The flag first reads 1 after the third rising clock edge that follows the input change, and not after the second.
- R4: A key whose bit in the enable register (address 1, bit n for key n) is 0 never sets the flag.
- R5: In mode 0, a key held low after its edge was acknowledged does not set the flag again, and a 0-to-1 change never sets it.
- R6: In mode 1, an enabled key held low keeps the flag set, and an acknowledge has no effect until every enabled key reads high. An acknowledge after that clears the flag.
- R7: `irq_o` equals flag AND NOT mask. With the mask at 1 the flag is still recorded, and clearing the mask raises `irq_o` at once.
- R8: Outside a break, writing address 0 with bit 2 at 1 clears the flag by the next clock. Writing bit 2 at 0 leaves the flag unchanged. A new trigger in the same cycle takes priority over the clear.
- R9: While `brk_active_i` is 1 and `brk_clr_en_i` is 0, an acknowledge write leaves the flag unchanged.
- R10: While `brk_active_i` and `brk_clr_en_i` are both 1, an acknowledge clears the flag, and the flag stays 0 after the break ends if no new trigger comes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, free-running in stop mode |
| rst | input | 1 | Synchronous active-high reset |
| key_n_i | input | NUM_KEYS | Active-low key inputs, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | Write address: 0 control, 1 enables |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 1 | Read address: 0 control, 1 enables |
| rd_data_o | output | 8 | Read data, combinational |
| brk_active_i | input | 1 | Debugger break state is active |
| brk_clr_en_i | input | 1 | Allows flag clearing during break |
| irq_o | output | 1 | Interrupt and wake-up request |

## Verification
Directed sequences first drive a single enabled key through fall, hold and release in each mode. This separates edge triggering from level triggering, and shows the exact three-edge latency. The same key patterns then run on a disabled key and with the mask set, which tells the enable path apart from the flag and request path. Acknowledges come in three cases: outside a break, in a break with permission, and in a break without it. These three cases separate the break gating from the plain clear. A long run with random key toggles, enables, control writes and break settings is checked cycle by cycle against a bench model. It covers the overlap of triggers and acknowledges that the directed cases do not reach.

// File: rtl/kbd_pkg.sv
package kbd_pkg;

    localparam int REG_W  = 8;
    localparam int B_FLAG = 3;
    localparam int B_ACK  = 2;
    localparam int B_MASK = 1;
    localparam int B_MODE = 0;

    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_EN   = 1'b1;

    typedef enum logic {
        TRIG_FALL       = 1'b0,
        TRIG_FALL_LEVEL = 1'b1
    } trig_e;

    typedef struct packed {
        logic  mask;
        trig_e mode;
    } ctrl_t;

    function automatic logic [REG_W-1:0] pack_ctrl(input logic flag, input ctrl_t c);
        logic [REG_W-1:0] v;
        v         = '0;
        v[B_FLAG] = flag;
        v[B_MASK] = c.mask;
        v[B_MODE] = c.mode;
        return v;
    endfunction

endpackage

// File: rtl/kbd_sync.sv
module kbd_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic st1_q;
        logic st2_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                st1_q <= 1'b1;
                st2_q <= 1'b1;
            end else begin
                st1_q <= async_i[i];
                st2_q <= st1_q;
            end
        end
        assign sync_o[i] = st2_q;
    end
endmodule

// File: rtl/kbd_detect.sv
module kbd_detect
    import kbd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] key_s_i,
    input  logic [W-1:0] en_i,
    input  trig_e        mode_i,
    output logic         set_o,
    output logic         any_low_o
);
    logic [W-1:0] prev_q;
    logic [W-1:0] fall;
    logic [W-1:0] low;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '1;
        else     prev_q <= key_s_i;
    end

    always_comb begin
        fall      = en_i & prev_q & ~key_s_i;
        low       = en_i & ~key_s_i;
        any_low_o = |low;
        set_o     = (|fall) || ((mode_i == TRIG_FALL_LEVEL) && any_low_o);
    end
endmodule

// File: rtl/kbd_regs.sv
module kbd_regs
    import kbd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en_i,
    input  logic             wr_addr_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic             rd_addr_i,
    output logic [REG_W-1:0] rd_data_o,
    input  logic             brk_active_i,
    input  logic             brk_clr_en_i,
    input  logic             set_i,
    output logic             flag_o,
    output ctrl_t            ctrl_o,
    output logic [W-1:0]     en_o
);
    logic             flag_q;
    ctrl_t            ctrl_q;
    logic [W-1:0]     en_q;
    logic             wr_ctrl;
    logic             ack_ok;
    logic [REG_W-1:0] en_ext;

    assign wr_ctrl = wr_en_i && (wr_addr_i == ADDR_CTRL);
    assign ack_ok  = wr_ctrl && wr_data_i[B_ACK] && (!brk_active_i || brk_clr_en_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            ctrl_q <= '{mask: 1'b0, mode: TRIG_FALL};
            en_q   <= '0;
        end else begin
            if (set_i)       flag_q <= 1'b1;
            else if (ack_ok) flag_q <= 1'b0;
            if (wr_ctrl) begin
                ctrl_q.mask <= wr_data_i[B_MASK];
                ctrl_q.mode <= trig_e'(wr_data_i[B_MODE]);
            end
            if (wr_en_i && (wr_addr_i == ADDR_EN))
                en_q <= wr_data_i[W-1:0];
        end
    end

    always_comb begin
        en_ext         = '0;
        en_ext[W-1:0]  = en_q;
        rd_data_o      = (rd_addr_i == ADDR_CTRL) ? pack_ctrl(flag_q, ctrl_q) : en_ext;
    end

    assign flag_o = flag_q;
    assign ctrl_o = ctrl_q;
    assign en_o   = en_q;
endmodule

// File: rtl/kbd_wake_ctrl.sv
module kbd_wake_ctrl
    import kbd_pkg::*;
#(
    parameter int NUM_KEYS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_KEYS-1:0] key_n_i,
    input  logic                wr_en_i,
    input  logic                wr_addr_i,
    input  logic [7:0]          wr_data_i,
    input  logic                rd_addr_i,
    output logic [7:0]          rd_data_o,
    input  logic                brk_active_i,
    input  logic                brk_clr_en_i,
    output logic                irq_o
);
    logic [NUM_KEYS-1:0] key_s;
    logic [NUM_KEYS-1:0] en;
    logic                set_evt;
    logic                any_low;
    logic                flag;
    ctrl_t               ctrl;

    kbd_sync #(.W(NUM_KEYS)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (key_n_i),
        .sync_o  (key_s)
    );

    kbd_detect #(.W(NUM_KEYS)) u_detect (
        .clk       (clk),
        .rst       (rst),
        .key_s_i   (key_s),
        .en_i      (en),
        .mode_i    (ctrl.mode),
        .set_o     (set_evt),
        .any_low_o (any_low)
    );

    kbd_regs #(.W(NUM_KEYS)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .wr_en_i      (wr_en_i),
        .wr_addr_i    (wr_addr_i),
        .wr_data_i    (wr_data_i),
        .rd_addr_i    (rd_addr_i),
        .rd_data_o    (rd_data_o),
        .brk_active_i (brk_active_i),
        .brk_clr_en_i (brk_clr_en_i),
        .set_i        (set_evt),
        .flag_o       (flag),
        .ctrl_o       (ctrl),
        .en_o         (en)
    );

    assign irq_o = flag && !ctrl.mask;
endmodule

// File: rtl/kbd_wake_chk.sv
module kbd_wake_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en_i,
    input logic       wr_addr_i,
    input logic       ack_bit,
    input logic       rd_addr_i,
    input logic [4:0] rd_zero_bits,
    input logic       brk_active_i,
    input logic       brk_clr_en_i,
    input logic       irq_o,
    input logic       flag,
    input logic       mask,
    input logic       mode,
    input logic       set_evt,
    input logic       any_low
);
    AST_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_addr_i == 1'b0) |-> (rd_zero_bits == 5'b0)); // R2

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        (!flag && !set_evt) |=> !flag); // R3

    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mode && any_low && flag) |=> flag); // R6

    AST_IRQ_MASK: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (flag && !mask)); // R7

    AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && !wr_addr_i && ack_bit && (!brk_active_i || brk_clr_en_i) && !set_evt)
        |=> !flag); // R8

    AST_BRK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (flag && brk_active_i && !brk_clr_en_i) |=> flag); // R9
endmodule

bind kbd_wake_ctrl kbd_wake_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en_i      (wr_en_i),
    .wr_addr_i    (wr_addr_i),
    .ack_bit      (wr_data_i[2]),
    .rd_addr_i    (rd_addr_i),
    .rd_zero_bits ({rd_data_o[7:4], rd_data_o[2]}),
    .brk_active_i (brk_active_i),
    .brk_clr_en_i (brk_clr_en_i),
    .irq_o        (irq_o),
    .flag         (flag),
    .mask         (ctrl.mask),
    .mode         (ctrl.mode),
    .set_evt      (set_evt),
    .any_low      (any_low)
);

// File: tb/test_kbd_wake_ctrl.sv
module test_kbd_wake_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NK         = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NK-1:0] key_n_i = '1;
    logic          wr_en_i = 1'b0;
    logic          wr_addr_i = 1'b0;
    logic [7:0]    wr_data_i = '0;
    logic          rd_addr_i = 1'b0;
    logic [7:0]    rd_data_o;
    logic          brk_active_i = 1'b0;
    logic          brk_clr_en_i = 1'b0;
    logic          irq_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    kbd_wake_ctrl #(.NUM_KEYS(NK)) i_kbd_wake_ctrl (
        .clk(clk), .rst(rst), .key_n_i(key_n_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
        .brk_active_i(brk_active_i), .brk_clr_en_i(brk_clr_en_i), .irq_o(irq_o)
    );

    int n_run = 0;
    int n_fail = 0;

    // bench reference model of the requirements
    logic [NK-1:0] m_s1 = '1, m_s2 = '1, m_prev = '1, m_en = '0;
    logic          m_flag = 1'b0, m_mask = 1'b0, m_mode = 1'b0;

    function automatic logic model_trigger(input logic [NK-1:0] en, prev, s, input logic mode);
        return (|(en & prev & ~s)) || (mode && (|(en & ~s)));
    endfunction

    function automatic logic [7:0] model_ctrl_read(input logic f, mk, md);
        return {4'b0000, f, 1'b0, mk, md};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic read_reg(input logic a, output logic [7:0] v);
        rd_addr_i = a;
        #1;
        v = rd_data_o;
    endtask

    // one clock: inputs held across a rising edge, returns after the falling edge
    task automatic step(input logic [NK-1:0] keys, input logic we, input logic wa,
                        input logic [7:0] wd, input logic brk, input logic bce);
        logic trig, ack, nflag;
        key_n_i      = keys;
        wr_en_i      = we;
        wr_addr_i    = wa;
        wr_data_i    = wd;
        brk_active_i = brk;
        brk_clr_en_i = bce;
        @(posedge clk);
        trig  = model_trigger(m_en, m_prev, m_s2, m_mode);
        ack   = we && !wa && wd[2] && (!brk || bce);
        nflag = trig ? 1'b1 : (ack ? 1'b0 : m_flag);
        if (we && !wa) begin m_mask = wd[1]; m_mode = wd[0]; end
        if (we && wa) m_en = wd[NK-1:0];
        m_prev = m_s2; m_s2 = m_s1; m_s1 = keys; m_flag = nflag;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic model_check(input string req);
        logic [7:0] v;
        read_reg(1'b0, v);
        check(req, v, model_ctrl_read(m_flag, m_mask, m_mode));
        check(req, {7'b0, irq_o}, {7'b0, m_flag & ~m_mask});
        read_reg(1'b1, v);
        check(req, v, m_en);
    endtask

    task automatic idle(input logic [NK-1:0] keys, input int n);
        for (int i = 0; i < n; i++) step(keys, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
    endtask

    task automatic expect_flag(input string req, input logic f);
        logic [7:0] v;
        read_reg(1'b0, v);
        check(req, {7'b0, v[3]}, {7'b0, f});
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        logic [NK-1:0] keys;
        logic brk, bce;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        read_reg(1'b0, v); check("R1", v, 8'h00);
        read_reg(1'b1, v); check("R1", v, 8'h00);
        check("R1", {7'b0, irq_o}, 8'h00);

        // R2 write all ones to control: only mask and mode stick
        step('1, 1'b1, 1'b0, 8'hFF, 1'b0, 1'b0);
        read_reg(1'b0, v); check("R2", v, 8'h03);
        step('1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0);

        // R3 edge latency on key 0
        step('1, 1'b1, 1'b1, 8'h01, 1'b0, 1'b0);
        step(8'hFE, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
        step(8'hFE, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
        expect_flag("R3", 1'b0);
        step(8'hFE, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
        expect_flag("R3", 1'b1);
        check("R7", {7'b0, irq_o}, 8'h01);

        // R8 ack bit 0 keeps, ack bit 1 clears
        step(8'hFE, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0);
        expect_flag("R8", 1'b1);
        step(8'hFE, 1'b1, 1'b0, 8'h04, 1'b0, 1'b0);
        expect_flag("R8", 1'b0);

        // R5 held low and release do not retrigger in mode 0
        idle(8'hFE, 4);
        expect_flag("R5", 1'b0);
        idle(8'hFF, 4);
        expect_flag("R5", 1'b0);

        // R4 disabled key 1 falls
        idle(8'hFD, 4);
        expect_flag("R4", 1'b0);
        idle(8'hFF, 2);

        // R7 mask set: flag recorded, no request
        step(8'hFF, 1'b1, 1'b0, 8'h02, 1'b0, 1'b0);
        idle(8'hFE, 4);
        expect_flag("R7", 1'b1);
        check("R7", {7'b0, irq_o}, 8'h00);
        step(8'hFE, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0);
        check("R7", {7'b0, irq_o}, 8'h01);
        step(8'hFE, 1'b1, 1'b0, 8'h04, 1'b0, 1'b0);
        idle(8'hFF, 3);

        // R9 break without permission
        idle(8'hFE, 3);
        expect_flag("R9", 1'b1);
        step(8'hFE, 1'b1, 1'b0, 8'h04, 1'b1, 1'b0);
        step(8'hFE, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
        expect_flag("R9", 1'b1);

        // R10 break with permission, stays cleared after break
        step(8'hFE, 1'b1, 1'b0, 8'h04, 1'b1, 1'b1);
        expect_flag("R10", 1'b0);
        idle(8'hFE, 3);
        expect_flag("R10", 1'b0);

        // R6 level mode with key 0 held low
        step(8'hFE, 1'b1, 1'b0, 8'h01, 1'b0, 1'b0);
        idle(8'hFE, 2);
        expect_flag("R6", 1'b1);
        step(8'hFE, 1'b1, 1'b0, 8'h05, 1'b0, 1'b0);
        expect_flag("R6", 1'b1);
        idle(8'hFF, 3);
        expect_flag("R6", 1'b1);
        step(8'hFF, 1'b1, 1'b0, 8'h05, 1'b0, 1'b0);
        expect_flag("R6", 1'b0);
        idle(8'hFF, 2);
        expect_flag("R6", 1'b0);
        model_check("R6");

        // random run against the model
        keys = '1; brk = 1'b0; bce = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            logic we, wa;
            logic [7:0] wd;
            if (($urandom % 4) == 0) keys[$urandom % NK] ^= 1'b1;
            if (($urandom % 32) == 0) begin brk = $urandom; bce = $urandom; end
            we = (($urandom % 6) == 0);
            wa = (($urandom % 5) == 0);
            wd = $urandom;
            step(keys, we, wa, wd, brk, bce);
            model_check(m_mode ? "R6" : "R3");
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule